// File: doc/BRIEF.md
# Floating-Point NaN Propagation Unit

This block sits beside a single-precision floating-point datapath and decides what the result must be when an operand is Not-a-Number. Every valid request carries two 32-bit IEEE 754 operands, an instruction-class code, a sign-operation code and a default-NaN mode bit. One clock later the block reports whether the NaN path overrides the normal result, and which 32-bit pattern is used if it does. The datapath itself is not part of the block. When `nan_hit` is high, the downstream merge logic takes `result`. Otherwise it takes its own computed value.

Arithmetic requests behave in one of two ways. In default-NaN mode, every NaN input collapses to the canonical quiet NaN. With that mode off, the block forwards an operand NaN and quiets it if it was signalling. Non-arithmetic requests (copy, negate, absolute value) keep the NaN payload and change only the sign bit. Load/store requests pass the bit pattern through untouched. A sticky invalid-operation flag records every signalling NaN seen by an arithmetic request. It stays set until an explicit clear.

Top module: `nan_prop_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `nan_hit` is high only together with `out_valid`, and only when an operand that the class examines is a NaN (exponent all ones, fraction non-zero). Whenever `nan_hit` is low, `result` is zero.
- R2: For an arithmetic request (`op_class`=00) with `dn_mode`=1 and at least one NaN operand, `result` is 0x7FC00000, whatever the payloads are.
- R3: An arithmetic request with a signalling NaN operand (NaN with fraction bit 22 clear) sets `inv_flag` on the following clock, in either mode. Quiet NaNs alone do not set it.
- R4: With `dn_mode`=0, an arithmetic request returns a signalling NaN operand with fraction bit 22 set. The sign and the remaining payload are kept.
- R5: With `dn_mode`=0 and two NaN operands, a signalling NaN wins over a quiet one. Between two NaNs of the same kind, operand A wins. A quiet NaN that is chosen is returned unchanged.
- R6: For a non-arithmetic request (`op_class`=01), a NaN in operand A is returned with only its sign changed: `sign_op` 00 or 11 copies it, 01 inverts bit 31, and 10 clears bit 31. This holds in both modes, no flag is raised, and operand B is ignored.
- R7: For a load/store request (`op_class`=10, and 11 treated the same way), a NaN in operand A is returned bit for bit in both modes. No flag is raised and operand B is ignored.
- R8: `inv_flag` is sticky and clears only on a clock where `flag_clr` is high. If a set and a clear fall on the same clock, the set wins.
- R9: A synchronous active-low reset clears `out_valid`, `nan_hit`, `result` and `inv_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_class | input | 2 | 00 arithmetic, 01 non-arithmetic, 10/11 load/store |
| sign_op | input | 2 | Non-arithmetic sign action: 00 copy, 01 negate, 10 absolute, 11 copy |
| dn_mode | input | 1 | 1 selects default-NaN substitution for arithmetic |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (arithmetic only) |
| flag_clr | input | 1 | Clears the sticky invalid flag |
| out_valid | output | 1 | Registered request strobe |
| nan_hit | output | 1 | NaN path overrides the datapath result |
| result | output | 32 | NaN result when `nan_hit` is high, otherwise zero |
| inv_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The hardest case to reach is a request where the sticky flag is set and cleared on the same clock, because the flag then shows a fresh set and not a clear. The bench produces this by raising `flag_clr` during the very cycle that carries a signalling-NaN arithmetic request. Two-NaN requests also need care, since they stress the priority between signalling and quiet NaNs and between operands. The vector table pairs signalling and quiet NaNs in both operand orders with distinct payloads, so a wrong choice shows up as a visible payload difference.

// File: rtl/nanp_pkg.sv
// Package: shared encodings for the NaN propagation unit.
// Assumes the instruction-class and sign-operation codes are stable in the
// requester's encoding; the top module casts its raw ports onto these types.
package nanp_pkg;

    typedef enum logic [1:0] {
        CLS_ARITH  = 2'b00,
        CLS_NONAR  = 2'b01,
        CLS_LDST   = 2'b10,
        CLS_LDST_X = 2'b11
    } op_class_e;

    typedef enum logic [1:0] {
        SGN_COPY   = 2'b00,
        SGN_NEG    = 2'b01,
        SGN_ABS    = 2'b10,
        SGN_COPY_X = 2'b11
    } sign_op_e;

endpackage

// File: rtl/nanp_classify.sv
// Module: nanp_classify
// Flags an IEEE 754 binary value as NaN and, if so, as signalling.
// Assumes the fraction MSB is the quiet bit (set = quiet).
module nanp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] value,
    output logic         is_nan,
    output logic         is_snan
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    // Split the value into its exponent and fraction fields.
    always_comb begin
        exp_f  = value[W-2 -: EXP_W];
        frac_f = value[FRAC_W-1:0];
    end

    // Decide NaN (all-ones exponent, non-zero fraction) and signalling (quiet bit clear).
    always_comb begin
        is_nan  = (&exp_f) && (|frac_f);
        is_snan = is_nan && !frac_f[FRAC_W-1];
    end

endmodule

// File: rtl/nanp_arith_pick.sv
// Module: nanp_arith_pick
// Chooses the NaN result of an arithmetic request and reports invalid.
// Assumes classification of both operands is already done.
// Priority with default-NaN off: SNaN over QNaN, operand A over B.
module nanp_arith_pick #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_nan,
    input  logic         a_snan,
    input  logic         b_nan,
    input  logic         b_snan,
    input  logic         dn_mode,
    output logic         hit,
    output logic [W-1:0] res,
    output logic         raise_inv
);

    localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);
    localparam logic [W-1:0] DFLT_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [W-1:0] chosen;

    // Pick the operand NaN by kind first, then by operand order.
    always_comb begin
        if (a_snan)      chosen = a;
        else if (b_snan) chosen = b;
        else if (a_nan)  chosen = a;
        else             chosen = b;
    end

    // Form the override result and the invalid indication.
    always_comb begin
        hit       = a_nan || b_nan;
        raise_inv = a_snan || b_snan;
        if (!hit)         res = '0;
        else if (dn_mode) res = DFLT_NAN;
        else              res = chosen | QUIET_BIT;
    end

endmodule

// File: rtl/nanp_sign_apply.sv
// Module: nanp_sign_apply
// Applies a copy/negate/absolute sign action to a NaN operand.
// Assumes only the sign bit may change; the payload is never quieted.
module nanp_sign_apply #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]          a,
    input  logic                  a_nan,
    input  nanp_pkg::sign_op_e    sop,
    output logic                  hit,
    output logic [W-1:0]          res
);

    logic sign_new;

    // Work out the new sign bit from the requested action.
    always_comb begin
        case (sop)
            nanp_pkg::SGN_NEG: sign_new = ~a[W-1];
            nanp_pkg::SGN_ABS: sign_new = 1'b0;
            default:           sign_new = a[W-1];
        endcase
    end

    // Pass the NaN through with the adjusted sign.
    always_comb begin
        hit = a_nan;
        res = a_nan ? {sign_new, a[W-2:0]} : '0;
    end

endmodule

// File: rtl/nan_prop_unit.sv
// Module: nan_prop_unit (top)
// Registered NaN override decision for single-precision operations.
// Assumes the datapath merges `result` when `nan_hit` is high; one cycle latency.
// The invalid flag is sticky; a set in the same cycle as a clear wins.
module nan_prop_unit #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int N_OPS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op_class,
    input  logic [1:0]   sign_op,
    input  logic         dn_mode,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         flag_clr,
    output logic         out_valid,
    output logic         nan_hit,
    output logic [W-1:0] result,
    output logic         inv_flag
);

    import nanp_pkg::*;

    localparam logic [W-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [W-1:0] opnd [N_OPS];
    logic         is_nan  [N_OPS];
    logic         is_snan [N_OPS];

    op_class_e    cls;
    sign_op_e     sop;

    logic         ar_hit, ar_inv, sg_hit;
    logic [W-1:0] ar_res, sg_res;

    logic         nx_hit, nx_inv;
    logic [W-1:0] nx_res;

    // Gather the operands into an indexable array and cast control codes.
    always_comb begin
        opnd[0] = opnd_a;
        opnd[1] = opnd_b;
        cls     = op_class_e'(op_class);
        sop     = sign_op_e'(sign_op);
    end

    // One classifier per operand.
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        nanp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
            .value   (opnd[gi]),
            .is_nan  (is_nan[gi]),
            .is_snan (is_snan[gi])
        );
    end

    nanp_arith_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_pick (
        .a         (opnd_a),
        .b         (opnd_b),
        .a_nan     (is_nan[0]),
        .a_snan    (is_snan[0]),
        .b_nan     (is_nan[1]),
        .b_snan    (is_snan[1]),
        .dn_mode   (dn_mode),
        .hit       (ar_hit),
        .res       (ar_res),
        .raise_inv (ar_inv)
    );

    nanp_sign_apply #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_sign (
        .a     (opnd_a),
        .a_nan (is_nan[0]),
        .sop   (sop),
        .hit   (sg_hit),
        .res   (sg_res)
    );

    // Select the override by instruction class.
    always_comb begin
        nx_hit = 1'b0;
        nx_res = '0;
        nx_inv = 1'b0;
        if (in_valid) begin
            case (cls)
                CLS_ARITH: begin
                    nx_hit = ar_hit;
                    nx_res = ar_res;
                    nx_inv = ar_inv;
                end
                CLS_NONAR: begin
                    nx_hit = sg_hit;
                    nx_res = sg_res;
                end
                default: begin
                    nx_hit = is_nan[0];
                    nx_res = is_nan[0] ? opnd_a : '0;
                end
            endcase
        end
    end

    // Register the decision and the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            nan_hit   <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            nan_hit   <= nx_hit;
            result    <= nx_res;
        end
    end

    // Maintain the sticky invalid flag; a new set overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) inv_flag <= 1'b0;
        else        inv_flag <= (inv_flag && !flag_clr) || nx_inv;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !nan_hit && result == '0)); // R1

    AST_HIT_NEEDS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_nan[0] && !is_nan[1]) |=> !nan_hit); // R1

    AST_DN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 2'b00 && dn_mode && (is_nan[0] || is_nan[1]))
        |=> (nan_hit && result == DFLT_NAN)); // R2

    AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 2'b00 && (is_snan[0] || is_snan[1])) |=> inv_flag); // R3

    AST_QUIETED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 2'b00 && !dn_mode && (is_nan[0] || is_nan[1]))
        |=> (nan_hit && result[FRAC_W-1])); // R4

    AST_NONAR_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 2'b01 && is_nan[0])
        |=> (nan_hit && result[W-2:0] == $past(opnd_a[W-2:0]))); // R6

    AST_LDST_VERBATIM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class[1] && is_nan[0]) |=> (nan_hit && result == $past(opnd_a))); // R7

    AST_NO_FLAG_NONARITH: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid && op_class == 2'b00)) |=> (!$rose(inv_flag))); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_flag && !flag_clr) |=> inv_flag); // R8

endmodule

// File: tb/test_nan_prop_unit.sv
// Bench: table of vectors walked by one loop, then directed reset and flag tests.
module test_nan_prop_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  op_class;
    logic [1:0]  sign_op;
    logic        dn_mode;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic        flag_clr;
    logic        out_valid;
    logic        nan_hit;
    logic [31:0] result;
    logic        inv_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nan_prop_unit i_nan_prop_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_class  (op_class),
        .sign_op   (sign_op),
        .dn_mode   (dn_mode),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .flag_clr  (flag_clr),
        .out_valid (out_valid),
        .nan_hit   (nan_hit),
        .result    (result),
        .inv_flag  (inv_flag)
    );

    // Layout: cls[102:101] sop[100:99] dn[98] a[97:66] b[65:34] hit[33] res[32:1] flag[0]
    localparam logic [102:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 1'b0, 32'h3F800000, 32'h40000000, 1'b0, 32'h00000000, 1'b0}, // R1 no NaN
        {2'd0, 2'd0, 1'b0, 32'h7F800000, 32'h3F800000, 1'b0, 32'h00000000, 1'b0}, // R1 infinity
        {2'd0, 2'd0, 1'b0, 32'h7FC12345, 32'h3F800000, 1'b1, 32'h7FC12345, 1'b0}, // R5 QNaN A
        {2'd0, 2'd0, 1'b0, 32'h3F800000, 32'hFFC00077, 1'b1, 32'hFFC00077, 1'b0}, // R5 QNaN B
        {2'd0, 2'd0, 1'b0, 32'h7FC12345, 32'hFFC00077, 1'b1, 32'h7FC12345, 1'b0}, // R5 A wins
        {2'd0, 2'd0, 1'b0, 32'h7FC12345, 32'hFFA00005, 1'b1, 32'hFFE00005, 1'b1}, // R5 SNaN B wins
        {2'd0, 2'd0, 1'b0, 32'h7F800001, 32'hFFA00005, 1'b1, 32'h7FC00001, 1'b1}, // R5 two SNaN
        {2'd0, 2'd0, 1'b0, 32'h3F800000, 32'h7F800001, 1'b1, 32'h7FC00001, 1'b1}, // R4 quiet
        {2'd0, 2'd0, 1'b0, 32'hFFA00005, 32'h3F800000, 1'b1, 32'hFFE00005, 1'b1}, // R4 sign kept
        {2'd0, 2'd0, 1'b1, 32'h7FC12345, 32'h3F800000, 1'b1, 32'h7FC00000, 1'b0}, // R2 QNaN
        {2'd0, 2'd0, 1'b1, 32'h3F800000, 32'hFFA00005, 1'b1, 32'h7FC00000, 1'b1}, // R2 R3 SNaN
        {2'd0, 2'd0, 1'b1, 32'hFFA00005, 32'hFFC00077, 1'b1, 32'h7FC00000, 1'b1}, // R2 both
        {2'd1, 2'd0, 1'b1, 32'h7F800001, 32'h00000000, 1'b1, 32'h7F800001, 1'b0}, // R6 copy
        {2'd1, 2'd1, 1'b0, 32'h7FC12345, 32'h00000000, 1'b1, 32'hFFC12345, 1'b0}, // R6 negate
        {2'd1, 2'd2, 1'b1, 32'hFFC00077, 32'h00000000, 1'b1, 32'h7FC00077, 1'b0}, // R6 abs
        {2'd1, 2'd1, 1'b0, 32'h3F800000, 32'hFFA00005, 1'b0, 32'h00000000, 1'b0}, // R6 B ignored
        {2'd1, 2'd3, 1'b0, 32'hFF800003, 32'h00000000, 1'b1, 32'hFF800003, 1'b0}, // R6 code 11
        {2'd2, 2'd1, 1'b0, 32'hFFA00005, 32'h7F800001, 1'b1, 32'hFFA00005, 1'b0}, // R7 SNaN raw
        {2'd2, 2'd0, 1'b1, 32'h7FC12345, 32'h00000000, 1'b1, 32'h7FC12345, 1'b0}, // R7 dn on
        {2'd3, 2'd0, 1'b0, 32'h3F800000, 32'h7F800001, 1'b0, 32'h00000000, 1'b0}  // R7 class 11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        in_valid = 1'b0; op_class = 2'd0; sign_op = 2'd0; dn_mode = 1'b0;
        opnd_a = '0; opnd_b = '0; flag_clr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        drive_idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check("R9 out_valid", 32'(out_valid), 32'd0);
        check("R9 nan_hit", 32'(nan_hit), 32'd0);
        check("R9 result", result, 32'd0);
        check("R9 inv_flag", 32'(inv_flag), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [102:0] v;
            v = VEC[i];
            // clear the flag first
            drive_idle();
            flag_clr = 1'b1;
            @(negedge clk);
            in_valid = 1'b1; flag_clr = 1'b0;
            op_class = v[102:101]; sign_op = v[100:99]; dn_mode = v[98];
            opnd_a = v[97:66]; opnd_b = v[65:34];
            @(negedge clk);
            check($sformatf("R1 vec%0d out_valid", i), 32'(out_valid), 32'd1);
            check($sformatf("R1 vec%0d nan_hit", i), 32'(nan_hit), 32'(v[33]));
            check($sformatf("R2/R4/R5/R6/R7 vec%0d result", i), result, v[32:1]);
            check($sformatf("R3 vec%0d inv_flag", i), 32'(inv_flag), 32'(v[0]));
            drive_idle();
        end

        // R1: idle cycle drops valid and result
        @(negedge clk);
        check("R1 idle out_valid", 32'(out_valid), 32'd0);
        check("R1 idle result", result, 32'd0);

        // R8: set flag, hold over idle cycles
        in_valid = 1'b1; opnd_a = 32'h7F800001;
        @(negedge clk);
        drive_idle();
        repeat (4) @(negedge clk);
        check("R8 sticky hold", 32'(inv_flag), 32'd1);
        // R3: quiet-only arithmetic leaves it as is; clear then QNaN
        flag_clr = 1'b1;
        @(negedge clk);
        check("R8 cleared", 32'(inv_flag), 32'd0);
        flag_clr = 1'b0; in_valid = 1'b1; opnd_a = 32'h7FC00001;
        @(negedge clk);
        check("R3 QNaN no flag", 32'(inv_flag), 32'd0);
        // R8: set and clear in the same cycle, set wins
        opnd_a = 32'h7F800001; flag_clr = 1'b1;
        @(negedge clk);
        check("R8 set beats clear", 32'(inv_flag), 32'd1);
        drive_idle();
        // R7: load/store SNaN does not raise flag after clear
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; in_valid = 1'b1; op_class = 2'd2; opnd_a = 32'h7F800001;
        @(negedge clk);
        check("R7 no flag", 32'(inv_flag), 32'd0);
        // R9: reset clears a set flag
        op_class = 2'd0;
        @(negedge clk);
        check("R3 flag set", 32'(inv_flag), 32'd1);
        drive_idle();
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 flag reset", 32'(inv_flag), 32'd0);
        check("R9 valid reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule